// File: doc/BRIEF.md
# Scaled Index Address Adder

This combinational unit forms array addresses by adding a base operand to an index operand that has been scaled by 2, 4 or 8. The scaling is a fixed left shift of one, two or three places placed directly in front of a single adder. The adder's delay therefore stays close to that of a plain add, with no general shifter in the path.

A second family of operations treats the index as an unsigned 32-bit word. The low 32 bits of the index operand are zero-extended to the datapath width before scaling, so a 32-bit unsigned loop counter can index a 64-bit address space directly. A separate immediate operation zero-extends the low word and shifts it left by a 6-bit amount. The datapath width is a parameter of 32 or 64. The word forms exist only at 64 bits.

An unsupported select raises a flag and forces the result to zero. Decoding instructions, reading registers and pipelining are left to the surrounding logic.

Top module: `scaled_index_adder`

## Requirements
- R1: With select 1, 2 or 3, the result is `base + (index << k)`, where k equals the select value and all XLEN bits of the index take part.
- R2: With select 0 (word add), the result is `base + zext(index[31:0])`.
- R3: With select 4, 5 or 6, the result is `base + (zext(index[31:0]) << k)`, where k is the select minus 3.
- R4: A word add with base equal to zero returns the index's low 32 bits zero-extended to XLEN.
- R5: With select 7 (word shift), the result is `zext(index[31:0]) << shamt`, where shamt is the 6-bit immediate (0 to 63). Bits shifted beyond XLEN are dropped.
- R6: All additions wrap modulo 2^XLEN, and no carry or overflow output exists.
- R7: Select codes 8 to 15 set `illegal` to 1 and force `result` to zero. All legal codes give `illegal` equal to 0.
- R8: When XLEN is 32, codes 0, 4, 5, 6 and 7 are also illegal and return zero, while codes 1 to 3 still work.
- R9: The shift immediate has no effect on the result for any select other than 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select, encoded as in R1 to R8 |
| index_in | input | XLEN | Index operand, scaled or zero-extended |
| base_in | input | XLEN | Base operand added to the scaled index |
| shamt | input | 6 | Immediate shift amount for the word shift |
| result | output | XLEN | Computed address |
| illegal | output | 1 | High for an unsupported select |

## Verification
On every evaluation, the assertions check four properties:
- an illegal select yields zero, and any code of 8 or above is flagged illegal;
- at 32 bits, every word form is flagged illegal;
- a word-form index never carries bits above bit 31;
- the low k bits of a full-width scaled sum equal those of the base, and a word shift leaves its low shamt bits clear.

Only the bench's scenarios can show that whole results are right. These include wrap-around at the top of the address range and independence from the shift immediate. They also include the exact boundary where upper index bits must be dropped or kept.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int unsigned SHAMT_W = 6;
  localparam int unsigned WORD_W  = 32;

  typedef enum logic [3:0] {
    OP_ADD_ZW = 4'd0,
    OP_SH1    = 4'd1,
    OP_SH2    = 4'd2,
    OP_SH3    = 4'd3,
    OP_SH1_ZW = 4'd4,
    OP_SH2_ZW = 4'd5,
    OP_SH3_ZW = 4'd6,
    OP_SHL_ZW = 4'd7
  } sia_op_e;

  typedef struct packed {
    logic       legal;
    logic       word_idx;
    logic       use_shl;
    logic [1:0] scale;
  } sia_ctrl_t;
endpackage

// File: rtl/sia_decode.sv
module sia_decode
  import sia_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [3:0] op_sel,
  output sia_ctrl_t  ctrl
);
  localparam bit WORD_OK = (XLEN > WORD_W);

  always_comb begin
    ctrl = '0;
    unique case (op_sel)
      OP_ADD_ZW: begin ctrl.word_idx = 1'b1; ctrl.legal = WORD_OK; end
      OP_SH1:    begin ctrl.scale = 2'd1; ctrl.legal = 1'b1; end
      OP_SH2:    begin ctrl.scale = 2'd2; ctrl.legal = 1'b1; end
      OP_SH3:    begin ctrl.scale = 2'd3; ctrl.legal = 1'b1; end
      OP_SH1_ZW: begin ctrl.scale = 2'd1; ctrl.word_idx = 1'b1; ctrl.legal = WORD_OK; end
      OP_SH2_ZW: begin ctrl.scale = 2'd2; ctrl.word_idx = 1'b1; ctrl.legal = WORD_OK; end
      OP_SH3_ZW: begin ctrl.scale = 2'd3; ctrl.word_idx = 1'b1; ctrl.legal = WORD_OK; end
      OP_SHL_ZW: begin ctrl.use_shl = 1'b1; ctrl.word_idx = 1'b1; ctrl.legal = WORD_OK; end
      default:   ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sia_index_cond.sv
module sia_index_cond
  import sia_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] index_in,
  input  logic            word_idx,
  output logic [XLEN-1:0] index_out
);
  localparam int unsigned HI_W = XLEN - WORD_W;

  generate
    if (XLEN > WORD_W) begin : g_wide
      logic [HI_W-1:0] hi_part;
      assign hi_part   = word_idx ? '0 : index_in[XLEN-1:WORD_W];
      assign index_out = {hi_part, index_in[WORD_W-1:0]};
    end else begin : g_narrow
      assign index_out = index_in;
    end
  endgenerate
endmodule

// File: rtl/sia_scale_add.sv
module sia_scale_add #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] index_val,
  input  logic [XLEN-1:0] base_val,
  input  logic [1:0]      scale,
  output logic [XLEN-1:0] scaled,
  output logic [XLEN-1:0] sum
);
  function automatic logic [XLEN-1:0] scale_by(input logic [XLEN-1:0] v,
                                               input logic [1:0] s);
    case (s)
      2'd0:    return v;
      2'd1:    return {v[XLEN-2:0], 1'b0};
      2'd2:    return {v[XLEN-3:0], 2'b00};
      default: return {v[XLEN-4:0], 3'b000};
    endcase
  endfunction

  assign scaled = scale_by(index_val, scale);
  assign sum    = base_val + scaled;
endmodule

// File: rtl/sia_word_shift.sv
module sia_word_shift
  import sia_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]    word_val,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [XLEN-1:0]    shifted
);
  assign shifted = word_val << shamt;
endmodule

// File: rtl/scaled_index_adder.sv
module scaled_index_adder
  import sia_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [3:0]         op_sel,
  input  logic [XLEN-1:0]    index_in,
  input  logic [XLEN-1:0]    base_in,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [XLEN-1:0]    result,
  output logic               illegal
);
  sia_ctrl_t       ctrl;
  logic            dec_legal;
  logic            dec_word;
  logic            dec_shl;
  logic [1:0]      dec_scale;
  logic [XLEN-1:0] idx_val;
  logic [XLEN-1:0] scaled_val;
  logic [XLEN-1:0] sum_val;
  logic [XLEN-1:0] shl_val;

  sia_decode #(.XLEN(XLEN)) u_decode (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  assign dec_legal = ctrl.legal;
  assign dec_word  = ctrl.word_idx;
  assign dec_shl   = ctrl.use_shl;
  assign dec_scale = ctrl.scale;

  sia_index_cond #(.XLEN(XLEN)) u_cond (
    .index_in  (index_in),
    .word_idx  (dec_word),
    .index_out (idx_val)
  );

  sia_scale_add #(.XLEN(XLEN)) u_add (
    .index_val (idx_val),
    .base_val  (base_in),
    .scale     (dec_scale),
    .scaled    (scaled_val),
    .sum       (sum_val)
  );

  sia_word_shift #(.XLEN(XLEN)) u_shl (
    .word_val (idx_val),
    .shamt    (shamt),
    .shifted  (shl_val)
  );

  always_comb begin
    if (!dec_legal)   result = '0;
    else if (dec_shl) result = shl_val;
    else              result = sum_val;
  end

  assign illegal = ~dec_legal;
endmodule

// File: rtl/sia_checker.sv
module sia_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic [3:0]      op_sel,
  input logic [XLEN-1:0] base_in,
  input logic [5:0]      shamt,
  input logic [XLEN-1:0] result,
  input logic            illegal,
  input logic            dec_word,
  input logic            dec_shl,
  input logic [1:0]      dec_scale,
  input logic [XLEN-1:0] idx_val
);
  logic [XLEN-1:0] scale_mask;
  logic [XLEN-1:0] shl_mask;

  assign scale_mask = (XLEN'(1) << dec_scale) - XLEN'(1);
  assign shl_mask   = (XLEN'(1) << shamt) - XLEN'(1);

  always_comb begin
    if (illegal)
      AST_ILLEGAL_ZERO: assert (result == '0);                                  // R7
    if (op_sel[3])
      AST_HIGH_CODE_FLAGGED: assert (illegal);                                  // R7
    if (XLEN == 32 && dec_word)
      AST_NARROW_WORD_ILLEGAL: assert (illegal);                                // R8
    if (!illegal && dec_word && XLEN > 32)
      AST_WORD_INDEX_CLEAN: assert ((idx_val >> 32) == '0);                     // R3
    if (!illegal && !dec_word && !dec_shl)
      AST_SCALED_LOW_BITS: assert (((result ^ base_in) & scale_mask) == '0);    // R1
    if (!illegal && dec_shl)
      AST_SHIFT_LOW_CLEAR: assert ((result & shl_mask) == '0);                  // R5
  end
endmodule

bind scaled_index_adder sia_checker #(.XLEN(XLEN)) u_sia_checker (
  .op_sel    (op_sel),
  .base_in   (base_in),
  .shamt     (shamt),
  .result    (result),
  .illegal   (illegal),
  .dec_word  (dec_word),
  .dec_shl   (dec_shl),
  .dec_scale (dec_scale),
  .idx_val   (idx_val)
);

// File: tb/scaled_index_adder_bench.sv
module scaled_index_adder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [3:0]  op64, op32;
  logic [63:0] a64, b64, r64;
  logic [31:0] a32, b32, r32;
  logic [5:0]  sh64, sh32;
  logic        il64, il32;

  scaled_index_adder #(.XLEN(64)) u_scaled_index_adder (
    .op_sel(op64), .index_in(a64), .base_in(b64), .shamt(sh64),
    .result(r64), .illegal(il64));

  scaled_index_adder #(.XLEN(32)) u_scaled_index_adder_w32 (
    .op_sel(op32), .index_in(a32), .base_in(b32), .shamt(sh32),
    .result(r32), .illegal(il32));

  function automatic string tag_of(input logic [3:0] op);
    if (op >= 4'd8) return "R7";
    if (op == 4'd0) return "R2";
    if (op <= 4'd3) return "R1";
    if (op <= 4'd6) return "R3";
    return "R5";
  endfunction

  // Reference: scaling written as a multiply, word extraction as a mask.
  function automatic logic [64:0] model64(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [5:0] sh);
    logic [63:0] lo = a & 64'h0000_0000_FFFF_FFFF;
    logic [63:0] v;
    case (op)
      4'd0: v = b + lo;
      4'd1: v = b + a * 64'd2;
      4'd2: v = b + a * 64'd4;
      4'd3: v = b + a * 64'd8;
      4'd4: v = b + lo * 64'd2;
      4'd5: v = b + lo * 64'd4;
      4'd6: v = b + lo * 64'd8;
      4'd7: v = lo << sh;
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, v};
  endfunction

  function automatic logic [32:0] model32(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
    case (op)
      4'd1: return {1'b0, b + a * 32'd2};
      4'd2: return {1'b0, b + a * 32'd4};
      4'd3: return {1'b0, b + a * 32'd8};
      default: return {1'b1, 32'd0};
    endcase
  endfunction

  task automatic run64(input string tag, input logic [3:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] sh);
    logic [64:0] exp;
    op64 = op; a64 = a; b64 = b; sh64 = sh;
    @(negedge clk);
    exp = model64(op, a, b, sh);
    tests++;
    if (r64 !== exp[63:0] || il64 !== exp[64]) begin
      fails++;
      $display("FAIL %s op=%0d: got %h/%b expected %h/%b", tag, op, r64, il64, exp[63:0], exp[64]);
    end
  endtask

  task automatic run32(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [5:0] sh);
    logic [32:0] exp;
    op32 = op; a32 = a; b32 = b; sh32 = sh;
    @(negedge clk);
    exp = model32(op, a, b);
    tests++;
    if (r32 !== exp[31:0] || il32 !== exp[32]) begin
      fails++;
      $display("FAIL %s w32 op=%0d: got %h/%b expected %h/%b", tag, op, r32, il32, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    logic [63:0] ra, rb;
    logic [3:0]  rop;
    void'($urandom(32'd1234));
    op64 = 4'd8; a64 = '1; b64 = '1; sh64 = '0;
    op32 = 4'd8; a32 = '1; b32 = '1; sh32 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Start-up: unsupported select gives zero and flag (R7)
    run64("R7", 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 6'd0);
    run64("R7", 4'd15, 64'h5, 64'h7, 6'd3);
    // R1 full-width scaling keeps upper index bits
    run64("R1", 4'd1, 64'h8000_0001_0000_0003, 64'h10, 6'd0);
    run64("R1", 4'd3, 64'h0000_0001_0000_0000, 64'h0, 6'd0);
    // R2 word add drops upper index bits
    run64("R2", 4'd0, 64'hDEAD_BEEF_0000_0010, 64'h1000, 6'd0);
    // R4 zero-extension via word add with zero base
    run64("R4", 4'd0, 64'hFFFF_FFFF_8000_0000, 64'h0, 6'd0);
    // R3 word scaling: bit 31 carried into bit 34, upper bits cleared
    run64("R3", 4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd0);
    run64("R3", 4'd4, 64'h1_8000_0000, 64'h1, 6'd0);
    // R5 word shift at 0, 32 and 63
    run64("R5", 4'd7, 64'hAAAA_AAAA_FFFF_FFFF, 64'h99, 6'd0);
    run64("R5", 4'd7, 64'h1234_5678_9ABC_DEF1, 64'h0, 6'd32);
    run64("R5", 4'd7, 64'h0000_0000_0000_0003, 64'h0, 6'd63);
    // R6 wrap at top of address range
    run64("R6", 4'd3, 64'hF000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
    run64("R6", 4'd5, 64'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
    // R9 shamt ignored on adds
    run64("R9", 4'd2, 64'h55, 64'h100, 6'd63);
    run64("R9", 4'd0, 64'h55, 64'h100, 6'd17);
    // R8 narrow datapath: word forms illegal, full forms fine
    run32("R8", 4'd0, 32'h1, 32'h2, 6'd0);
    run32("R8", 4'd5, 32'h1, 32'h2, 6'd0);
    run32("R8", 4'd7, 32'hFF, 32'h0, 6'd4);
    run32("R8", 4'd1, 32'h8000_0001, 32'h3, 6'd0);
    run32("R8", 4'd3, 32'hFFFF_FFFF, 32'h7, 6'd9);
    // Random mix, both widths
    for (int i = 0; i < 3000; i++) begin
      ra  = {$urandom, $urandom};
      rb  = {$urandom, $urandom};
      rop = 4'($urandom_range(0, 9));
      run64(tag_of(rop), rop, ra, rb, 6'($urandom));
      run32((rop inside {4'd1, 4'd2, 4'd3}) ? "R1" : "R8", rop, ra[31:0], rb[31:0], 6'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule